// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a small synchronous static RAM with a burst address sequencer and a registered read pipeline. A word is 36 bits wide and is split into four byte lanes of nine bits each. The depth is set by an address-width parameter. Address, control and write data are taken on the rising clock edge. A read result is held in a two-register pipeline before it reaches the output.

An access starts when one of two address strobes is low. The processor strobe counts only while the chip enable is low. The controller strobe always counts. Once a burst is open, cycles with both strobes high either step the two low address bits through a four-word sequence or hold the current address. The order of that sequence is linear or interleaved, chosen by a static input. Writes use three levels of control: a global write, a byte-write enable, and one write bit per lane. The output-valid flag is the model of the output drivers. It drops at once when output enable is high, when sleep is high, or when the current cycle is a write.

The controller has two states. ST_DESEL is entered on reset, on sleep, and on any strobe cycle that fails the select test. ST_BURST is entered on any strobe cycle that passes the select test. It stays there on continue and suspend cycles until a failed strobe or sleep returns it to ST_DESEL.

Top module: `burst_sram`

## Requirements
- R1: After reset the block is deselected. rdata_vld is 0, and cycles with both strobes high produce no output until a selecting strobe cycle arrives.
- R2: A strobe cycle selects the block only when cen_n=0, sel_hi=1 and sel_lo_n=0. A strobe cycle that fails this test is a deselect. The read issued on the cycle before it is still delivered, and rdata_vld is 0 from the second edge after the deselect edge on.
- R3: strb_cpu_n=0 counts as a strobe only while cen_n=0. With cen_n=1 and strb_ctl_n=1 the cycle is a continue or suspend cycle, and addr_i is not loaded.
- R4: A read whose address is taken at edge k loads its word into the output register at edge k+1. Each later burst word follows on the next edge.
- R5: On a continue or suspend cycle, step_n=0 moves the 2-bit burst count up by one, and step_n=1 holds it. After four steps the count wraps back to the start address.
- R6: The low two address bits of a burst access are derived from the start address. With seq_linear=1 they are (start + count) mod 4. With seq_linear=0 they are start XOR count. The upper address bits do not change during a burst.
- R7: When wr_all_n=0, all four lanes are written. Otherwise, when lane_en_n=0, each lane N with lane_wr_n[N]=0 is written. When wr_all_n=1 and lane_en_n=1, the cycle is a read whatever lane_wr_n holds.
- R8: Lane N covers wdata/rdata bits 8N+7..8N plus bit 32+N. Any subset of lanes may be written in one cycle, and the other lanes keep their contents.
- R9: On a cycle started by the processor strobe, the write controls are ignored and the cycle reads. A cycle started by the controller strobe writes if its write controls, sampled on that same edge, ask for a write. A continue cycle after a processor-strobe start writes the held address if its write controls ask for it.
- R10: rdata_vld is 0 while oe_n=1, while sleep=1, or while the inputs currently applied decode to a write. Otherwise it shows the pipeline's valid bit.
- R11: While sleep=1, edges perform no access and do not change memory. Sleep clears the read pipeline and leaves the block in ST_DESEL after sleep ends.
- R12: Continue and suspend cycles of an open burst work regardless of cen_n, sel_hi and sel_lo_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address taken on a strobe cycle |
| cen_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_hi | input | 1 | Chip select, active high |
| sel_lo_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| lane_en_n | input | 1 | Enables the per-lane write bits, active low |
| lane_wr_n | input | LANES | Per-lane write, active low |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved; static |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep, active high |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Read data from the output register |
| rdata_vld | output | 1 | Output-drive flag; rdata is meaningful when 1 |

## Verification
Read data and the off state after a deselect both appear one edge after the edge that issued them. The address edge is k and the result is visible once edge k+1 has passed. The gating by oe_n, sleep and write cycles acts in the same cycle as those inputs. The driver runs a reference of the memory and burst rules. For each edge it queues the value the output register must hold after that edge, tagged with that edge's number. The monitor pops the entry at the falling edge of the same cycle, and only then applies the gating from the inputs currently driven. Each comparison is therefore made in the cycle where the result is due, and never one edge early or late.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int BURST_W = 2;

    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_BURST = 1'b1
    } bst_t;

    // low address bits for a given burst count
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               linear
    );
        return linear ? (start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             cen_n,
    input  logic             sel_hi,
    input  logic             sel_lo_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_all_n,
    input  logic             lane_en_n,
    input  logic [LANES-1:0] lane_wr_n,
    output logic             load,
    output logic             adv,
    output logic             acc_rd,
    output logic             wr_now,
    output logic [LANES-1:0] wmask,
    output bst_t             state
);

    bst_t             nxt;
    logic             cpu_go;
    logic             ctl_go;
    logic             chosen;
    logic             wr_req;
    logic [LANES-1:0] req_mask;

    assign cpu_go   = !strb_cpu_n && !cen_n;
    assign ctl_go   = !strb_ctl_n;
    assign chosen   = !cen_n && sel_hi && !sel_lo_n;
    assign req_mask = !wr_all_n ? {LANES{1'b1}} :
                      (!lane_en_n ? ~lane_wr_n : {LANES{1'b0}});
    assign wr_req   = |req_mask;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DESEL;
        else        state <= nxt;
    end

    // decode and next state
    always_comb begin
        nxt    = state;
        load   = 1'b0;
        adv    = 1'b0;
        acc_rd = 1'b0;
        wr_now = 1'b0;
        if (sleep) begin
            nxt = ST_DESEL;
        end else if (cpu_go || ctl_go) begin
            if (chosen) begin
                nxt  = ST_BURST;
                load = 1'b1;
                if (ctl_go && !cpu_go && wr_req) wr_now = 1'b1;
                else                             acc_rd = 1'b1;
            end else begin
                nxt = ST_DESEL;
            end
        end else begin
            unique case (state)
                ST_DESEL: nxt = ST_DESEL;
                ST_BURST: begin
                    adv = !step_n;
                    if (wr_req) wr_now = 1'b1;
                    else        acc_rd = 1'b1;
                end
            endcase
        end
    end

    assign wmask = wr_now ? req_mask : {LANES{1'b0}};

endmodule

// File: rtl/bsram_seq.sv
module bsram_seq
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:0]  base;
    logic [BURST_W-1:0] cnt;
    logic [BURST_W-1:0] nxt_cnt;

    assign nxt_cnt  = adv ? cnt + 1'b1 : cnt;
    assign acc_addr = load ? addr_i :
                      {base[ADDR_W-1:BURST_W], burst_low(base[BURST_W-1:0], nxt_cnt, linear)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base <= '0;
            cnt  <= '0;
        end else if (load) begin
            base <= addr_i;
            cnt  <= '0;
        end else if (adv) begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int ADDR_W    = 6,
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8
) (
    input  logic                            clk,
    input  logic [LANES-1:0]                wmask,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [LANES*(LANE_BITS+1)-1:0]  wdata,
    output logic [LANES*(LANE_BITS+1)-1:0]  rdata
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int DBITS = LANES * LANE_BITS;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_BITS:0] mem [DEPTH];
        logic [LANE_BITS:0] rbuf;
        logic [LANE_BITS:0] lane_in;

        assign lane_in = {wdata[DBITS + g], wdata[g*LANE_BITS +: LANE_BITS]};

        always_ff @(posedge clk) begin
            if (wmask[g]) mem[addr] <= lane_in;
            if (rd_en)    rbuf      <= mem[addr];
        end

        assign rdata[g*LANE_BITS +: LANE_BITS] = rbuf[LANE_BITS-1:0];
        assign rdata[DBITS + g]                = rbuf[LANE_BITS];
    end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int LANES     = 4,
    parameter int LANE_BITS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic                           cen_n,
    input  logic                           sel_hi,
    input  logic                           sel_lo_n,
    input  logic                           strb_cpu_n,
    input  logic                           strb_ctl_n,
    input  logic                           step_n,
    input  logic                           wr_all_n,
    input  logic                           lane_en_n,
    input  logic [LANES-1:0]               lane_wr_n,
    input  logic                           seq_linear,
    input  logic                           oe_n,
    input  logic                           sleep,
    input  logic [LANES*(LANE_BITS+1)-1:0] wdata,
    output logic [LANES*(LANE_BITS+1)-1:0] rdata,
    output logic                           rdata_vld
);

    localparam int DW = LANES * (LANE_BITS + 1);

    logic              load;
    logic              adv;
    logic              acc_rd;
    logic              wr_now;
    logic [LANES-1:0]  wmask;
    bst_t              state;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     arr_q;
    logic              rd1_vld;
    logic              out_vld;
    logic [DW-1:0]     out_data;

    bsram_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep      (sleep),
        .cen_n      (cen_n),
        .sel_hi     (sel_hi),
        .sel_lo_n   (sel_lo_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .step_n     (step_n),
        .wr_all_n   (wr_all_n),
        .lane_en_n  (lane_en_n),
        .lane_wr_n  (lane_wr_n),
        .load       (load),
        .adv        (adv),
        .acc_rd     (acc_rd),
        .wr_now     (wr_now),
        .wmask      (wmask),
        .state      (state)
    );

    bsram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .linear   (seq_linear),
        .addr_i   (addr_i),
        .acc_addr (acc_addr)
    );

    bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_arr (
        .clk   (clk),
        .wmask (wmask),
        .rd_en (acc_rd),
        .addr  (acc_addr),
        .wdata (wdata),
        .rdata (arr_q)
    );

    // second pipeline stage: output register, single-cycle deselect
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd1_vld  <= 1'b0;
            out_vld  <= 1'b0;
            out_data <= '0;
        end else if (sleep) begin
            rd1_vld  <= 1'b0;
            out_vld  <= 1'b0;
        end else begin
            rd1_vld  <= acc_rd;
            out_vld  <= rd1_vld;
            if (rd1_vld) out_data <= arr_q;
        end
    end

    assign rdata     = out_data;
    assign rdata_vld = out_vld && !oe_n && !sleep && !wr_now;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             cen_n,
    input logic             sel_hi,
    input logic             sel_lo_n,
    input logic             strb_cpu_n,
    input logic             strb_ctl_n,
    input logic             wr_all_n,
    input logic             rdata_vld,
    input logic             load,
    input logic             acc_rd,
    input logic             wr_now,
    input logic [LANES-1:0] wmask,
    input logic             rd1_vld,
    input logic             out_vld,
    input bst_t             state
);

    logic strobe_in;
    logic desel_in;

    assign strobe_in = !strb_ctl_n || (!strb_cpu_n && !cen_n);
    assign desel_in  = !sleep && strobe_in && (cen_n || !sel_hi || sel_lo_n);

    p_desel_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        desel_in |=> ##1 !rdata_vld);

    p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && cen_n && strb_ctl_n) |-> !load);

    p_stage1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rd1_vld);

    p_stage2_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_vld && !sleep) |=> out_vld);

    p_global_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_all_n && wr_now) |-> (wmask == {LANES{1'b1}}));

    p_cpu_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !strb_cpu_n && !cen_n) |-> (!wr_now && $countones(wmask) == 0));

    p_write_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> !rd1_vld);

    p_sleep_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (state == ST_DESEL && !out_vld));

    p_sleep_nowrite_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (wmask == '0 && !load));

endmodule

bind burst_sram bsram_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .cen_n      (cen_n),
    .sel_hi     (sel_hi),
    .sel_lo_n   (sel_lo_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .wr_all_n   (wr_all_n),
    .rdata_vld  (rdata_vld),
    .load       (load),
    .acc_rd     (acc_rd),
    .wr_now     (wr_now),
    .wmask      (wmask),
    .rd1_vld    (rd1_vld),
    .out_vld    (out_vld),
    .state      (state)
);

// File: tb/burst_sram_tb.sv
`timescale 1ns/1ps
module burst_sram_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr_i;
    logic        cen_n, sel_hi, sel_lo_n, strb_cpu_n, strb_ctl_n, step_n;
    logic        wr_all_n, lane_en_n, seq_linear, oe_n, sleep;
    logic [3:0]  lane_wr_n;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        rdata_vld;

    always #10 clk = ~clk;

    burst_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cen_n(cen_n), .sel_hi(sel_hi),
        .sel_lo_n(sel_lo_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
        .step_n(step_n), .wr_all_n(wr_all_n), .lane_en_n(lane_en_n),
        .lane_wr_n(lane_wr_n), .seq_linear(seq_linear), .oe_n(oe_n), .sleep(sleep),
        .wdata(wdata), .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    int edge_cnt = 0;
    bit tb_wr_now = 0;

    // reference state
    logic [35:0] ref_mem [64];
    bit          m_busy = 0;
    logic [5:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;
    bit          m_p1_vld = 0;
    logic [35:0] m_p1_data = '0;

    // scoreboard queues
    int          q_due[$];
    bit          q_vld[$];
    logic [35:0] q_dat[$];
    string       q_tag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [35:0] act, input logic [35:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [35:0] pat(input int a);
        return {4'(a), 32'h13579BDF ^ (32'(a) * 32'h01010101)};
    endfunction

    function automatic logic [1:0] ord(input logic [1:0] b, input logic [1:0] c);
        return seq_linear ? b + c : b ^ c;
    endfunction

    task automatic idle();
        cen_n = 1; sel_hi = 1; sel_lo_n = 0; strb_cpu_n = 1; strb_ctl_n = 1;
        step_n = 1; wr_all_n = 1; lane_en_n = 1; lane_wr_n = 4'hF;
        oe_n = 0; sleep = 0; wdata = '0; addr_i = '0;
    endtask

    // apply current inputs to one edge and advance the reference
    task automatic tick(input string tag);
        bit cpu_go, ctl_go, chosen, wreq;
        int kind;
        logic [5:0] a;
        logic [1:0] ncnt;
        logic [3:0] m;
        cpu_go = !strb_cpu_n && !cen_n;
        ctl_go = !strb_ctl_n;
        chosen = !cen_n && sel_hi && !sel_lo_n;
        m      = !wr_all_n ? 4'hF : (!lane_en_n ? ~lane_wr_n : 4'h0);
        wreq   = (m != 4'h0);
        kind   = 0;
        a      = addr_i;
        ncnt   = m_cnt;
        if (sleep) kind = 0;
        else if (cpu_go || ctl_go) kind = chosen ? ((ctl_go && !cpu_go && wreq) ? 2 : 1) : 3;
        else if (m_busy) begin
            ncnt = step_n ? m_cnt : m_cnt + 2'd1;
            a    = {m_base[5:2], ord(m_base[1:0], ncnt)};
            kind = wreq ? 2 : 1;
        end
        tb_wr_now = (kind == 2);
        @(posedge clk);
        edge_cnt++;
        q_due.push_back(edge_cnt);
        q_vld.push_back(sleep ? 1'b0 : m_p1_vld);
        q_dat.push_back(m_p1_data);
        q_tag.push_back(tag);
        m_p1_vld = (kind == 1);
        if (kind == 1) m_p1_data = ref_mem[a];
        if (kind == 2)
            for (int l = 0; l < 4; l++)
                if (m[l]) begin
                    ref_mem[a][l*8 +: 8] = wdata[l*8 +: 8];
                    ref_mem[a][32+l]     = wdata[32+l];
                end
        if (sleep || kind == 3) m_busy = 0;
        else if (cpu_go || ctl_go) begin m_busy = 1; m_base = addr_i; m_cnt = '0; end
        else if (m_busy) m_cnt = ncnt;
        #2;
    endtask

    task automatic wr_ctl(input int a, input logic [35:0] d, input string tag);
        idle(); cen_n = 0; strb_ctl_n = 0; addr_i = 6'(a); wr_all_n = 0; wdata = d; tick(tag);
    endtask
    task automatic rd_ctl(input int a, input string tag);
        idle(); cen_n = 0; strb_ctl_n = 0; addr_i = 6'(a); tick(tag);
    endtask
    task automatic rd_cpu(input int a, input string tag);
        idle(); cen_n = 0; strb_cpu_n = 0; addr_i = 6'(a); tick(tag);
    endtask
    task automatic cont(input bit adv, input string tag);
        idle(); step_n = !adv; tick(tag);
    endtask
    task automatic desel(input string tag);
        idle(); strb_ctl_n = 0; tick(tag);
    endtask

    // monitor: compare the due output at the falling edge
    bit          mon_v;
    logic [35:0] mon_d;
    string       mon_t;
    int          mon_due;
    always @(negedge clk) begin
        if (q_due.size() > 0 && q_due[0] == edge_cnt) begin
            mon_due = q_due.pop_front();
            mon_v   = q_vld.pop_front() && !oe_n && !sleep && !tb_wr_now;
            mon_d   = q_dat.pop_front();
            mon_t   = q_tag.pop_front();
            check(rdata_vld == mon_v, mon_t, "rdata_vld", 36'(rdata_vld), 36'(mon_v));
            if (mon_v) check(rdata == mon_d, mon_t, "rdata", rdata, mon_d);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(); seq_linear = 1; rst_n = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        check(rdata_vld == 1'b0, "R1", "reset rdata_vld", 36'(rdata_vld), 36'd0);
        @(posedge clk); #2;
        for (int i = 0; i < 3; i++) cont(1, "R1");

        for (int a = 0; a < 16; a++) wr_ctl(a, pat(a), "R7");
        desel("R2");

        rd_cpu(3, "R4"); rd_cpu(5, "R4"); rd_ctl(9, "R4"); desel("R4"); cont(0, "R2");

        // linear burst from 5: 5,6,7,4 then wrap to 5
        rd_ctl(5, "R6"); cont(1, "R6"); cont(1, "R6"); cont(1, "R6"); cont(1, "R5");
        desel("R6");
        // interleaved burst from 6: 6,7,4,5
        seq_linear = 0;
        rd_ctl(6, "R6"); cont(1, "R6"); cont(1, "R6"); cont(1, "R6");
        desel("R6"); seq_linear = 1; cont(0, "R6");

        // suspend holds, then advance
        rd_cpu(10, "R5"); cont(0, "R5"); cont(0, "R5"); cont(1, "R5"); desel("R5");

        // byte lanes 0 and 2, then lane 3 only
        idle(); cen_n = 0; strb_ctl_n = 0; addr_i = 2; lane_en_n = 0;
        lane_wr_n = 4'b1010; wdata = 36'hE_89AB_CDEF; tick("R8");
        rd_ctl(2, "R8");
        idle(); cen_n = 0; strb_ctl_n = 0; addr_i = 4; lane_en_n = 0;
        lane_wr_n = 4'b0111; wdata = 36'h7_1122_3344; tick("R8");
        rd_ctl(4, "R8"); desel("R8");

        // lane bits blocked when lane_en_n high
        idle(); cen_n = 0; strb_ctl_n = 0; addr_i = 12; lane_wr_n = 4'h0; tick("R7");
        rd_ctl(12, "R7"); desel("R7");

        // processor strobe ignores write controls; next cycle writes
        idle(); cen_n = 0; strb_cpu_n = 0; addr_i = 13; wr_all_n = 0; wdata = '0; tick("R9");
        idle(); wr_all_n = 0; wdata = 36'hA_BCDE_F012; tick("R9");
        rd_ctl(13, "R9"); desel("R9");

        // processor strobe gated by cen_n; continue ignores selects
        rd_ctl(8, "R3");
        idle(); strb_cpu_n = 0; addr_i = 20; step_n = 0; tick("R3");
        idle(); sel_hi = 0; sel_lo_n = 1; step_n = 0; tick("R12");
        desel("R12");

        // single-cycle deselect after a read
        rd_ctl(3, "R2");
        idle(); cen_n = 0; sel_hi = 0; strb_ctl_n = 0; tick("R2");
        cont(1, "R2"); cont(1, "R2");
        idle(); cen_n = 0; sel_lo_n = 1; strb_cpu_n = 0; addr_i = 7; tick("R2");
        cont(0, "R2");

        // output gating by oe_n and by a write cycle
        rd_ctl(5, "R10"); cont(0, "R10");
        idle(); oe_n = 1; tick("R10");
        idle(); wr_all_n = 0; wdata = 36'h5_0F0F_0F0F; tick("R10");
        cont(0, "R10"); desel("R10");
        rd_ctl(5, "R10"); desel("R10"); cont(0, "R10");

        // sleep: clears pipeline, blocks writes, wakes deselected
        rd_ctl(7, "R11");
        idle(); sleep = 1; tick("R11");
        idle(); sleep = 1; cen_n = 0; strb_ctl_n = 0; wr_all_n = 0; addr_i = 7; tick("R11");
        idle(); sleep = 1; tick("R11");
        cont(1, "R11"); cont(1, "R11");
        rd_ctl(7, "R11"); desel("R11");
        for (int i = 0; i < 3; i++) cont(0, "R1");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule